// File: doc/BRIEF.md
# Masked-Stride DMA Address Generator

This block produces the source and destination address pair for a single DMA channel while the channel works through a fixed number of hops. For each address it keeps a start value, a live current value, a signed stride and a freeze mask. Software loads these through a small write port and then arms the channel. Each granted step moves both current addresses on by their strides. Any bit that is set in an address's mask keeps its value, so the unmasked low bits can wrap inside an aligned window and act as a circular buffer.

The channel is armed in one of two ways. A fresh start reloads the current addresses from the start values. A resume start keeps the current addresses where the last transfer left them. When the last hop is taken the block raises a sticky end flag. In one-shot mode it then disarms itself. In continuous mode it reloads the hop count and keeps stepping from the same position. The live addresses are always visible on the outputs, so the block also serves as the readback of the transfer position.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, chanEn, endFlag, hopLeft, srcAddr and dstAddr are all zero.
- R2: A write with cfgWr high loads the register that cfgSel selects from cfgData. The encoding is: 0 source start, 1 destination start, 2 source stride, 3 destination stride, 4 source mask, 5 destination mask, 6 hop count. A stride takes the low INC_W bits and the hop count takes the low HOP_W bits. If enSet is pulsed while the channel is disarmed, with resumeMode low and a non-zero hop count, then on the next cycle chanEn is 1, both addresses equal their start values and hopLeft equals the hop count.
- R3: stepAck is high in the same cycle as stepReq when the channel is armed with hops left. After that edge, each address becomes ((cur + stride) AND NOT mask) OR (cur AND mask). The stride is sign-extended two's complement, and the sum wraps modulo 2^ADDR_W.
- R4: Address bits that are set in the mask never change on a step.
- R5: Every acknowledged step lowers hopLeft by one. The step that takes the last hop sets endFlag.
- R6: With contMode low, the channel disarms after the last hop. While the channel is disarmed, stepReq is not acknowledged and the addresses hold.
- R7: With contMode high, the channel stays armed after the last hop. hopLeft is reloaded with the hop count, and the addresses keep advancing from where they are.
- R8: A start with resumeMode high keeps the current addresses. Right after reset these equal the reset start values, which are zero.
- R9: clrEnd clears endFlag on the next cycle. If an end event happens in the same cycle, the end event wins. Otherwise endFlag holds.
- R10: enSet while the channel is armed is ignored. Neither the addresses nor hopLeft change.
- R11: A start with a hop count of zero leaves chanEn low and sets endFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgData | input | ADDR_W | Configuration write data |
| enSet | input | 1 | Arm request (software enable write) |
| resumeMode | input | 1 | 1: start from current addresses |
| contMode | input | 1 | 1: stay armed and reload after the last hop |
| stepReq | input | 1 | Request one transfer step |
| clrEnd | input | 1 | Clear the end flag |
| stepAck | output | 1 | Step accepted this cycle; srcAddr/dstAddr are its pair |
| chanEn | output | 1 | Channel armed |
| srcAddr | output | ADDR_W | Current source address |
| dstAddr | output | ADDR_W | Current destination address |
| hopLeft | output | HOP_W | Hops remaining |
| endFlag | output | 1 | Sticky end-of-transfer flag |

## Verification
The bench builds the block with ADDR_W=12, INC_W=8 and HOP_W=4. The narrow address space puts wrap-around past the top of memory within a few steps, and an 8-bit stride makes negative strides easy to write. The 4-bit hop counter keeps every full one-shot, resume and continuous sequence short enough to follow step by step. Table vectors cover unit, negative and large strides, as well as masks that freeze high bits (circular window) or low bits.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

  // Configuration register select codes
  typedef enum logic [2:0] {
    SEL_SRC_START = 3'd0,
    SEL_DST_START = 3'd1,
    SEL_SRC_STEP  = 3'd2,
    SEL_DST_STEP  = 3'd3,
    SEL_SRC_HOLD  = 3'd4,
    SEL_DST_HOLD  = 3'd5,
    SEL_HOPS      = 3'd6
  } cfgSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // copy start values into current addresses
    logic advance;    // take one masked stride step
  } pathCtl_t;

  localparam int NUM_ADDR = 2;  // source and destination

endpackage

// File: rtl/dmaag_addr_unit.sv
module dmaag_addr_unit
  import dmaag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic              wrStep,
  input  logic              wrHold,
  input  logic [ADDR_W-1:0] cfgData,
  input  pathCtl_t          ctl,
  output logic [ADDR_W-1:0] curAddr
);

  logic [ADDR_W-1:0]        startReg;
  logic [INC_W-1:0]         stepReg;
  logic [ADDR_W-1:0]        holdReg;
  logic [ADDR_W-1:0]        curReg;
  logic signed [ADDR_W-1:0] stepExt;
  logic [ADDR_W-1:0]        sumAddr;
  logic [ADDR_W-1:0]        nextAddr;

  always_comb begin
    stepExt  = ADDR_W'($signed(stepReg));
    sumAddr  = curReg + stepExt;
    // frozen bits come from the current value, free bits from the sum
    nextAddr = (sumAddr & ~holdReg) | (curReg & holdReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      stepReg  <= '0;
      holdReg  <= '0;
    end else begin
      if (wrStart) startReg <= cfgData;
      if (wrStep)  stepReg  <= cfgData[INC_W-1:0];
      if (wrHold)  holdReg  <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              curReg <= '0;
    else if (ctl.loadStart) curReg <= startReg;
    else if (ctl.advance)   curReg <= nextAddr;
  end

  assign curAddr = curReg;

endmodule

// File: rtl/dmaag_path.sv
module dmaag_path
  import dmaag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  pathCtl_t          ctl,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);

  logic [ADDR_W-1:0] unitAddr [NUM_ADDR];

  for (genvar g = 0; g < NUM_ADDR; g++) begin : gen_unit
    // select codes: start = g, stride = 2+g, mask = 4+g
    localparam logic [2:0] SEL_START = 3'(g);
    localparam logic [2:0] SEL_STEP  = 3'(2 + g);
    localparam logic [2:0] SEL_HOLD  = 3'(4 + g);

    logic wrStart, wrStep, wrHold;
    assign wrStart = cfgWr && (cfgSel == SEL_START);
    assign wrStep  = cfgWr && (cfgSel == SEL_STEP);
    assign wrHold  = cfgWr && (cfgSel == SEL_HOLD);

    dmaag_addr_unit #(.ADDR_W(ADDR_W), .INC_W(INC_W)) unit_i (
      .clk     (clk),
      .rstN    (rstN),
      .wrStart (wrStart),
      .wrStep  (wrStep),
      .wrHold  (wrHold),
      .cfgData (cfgData),
      .ctl     (ctl),
      .curAddr (unitAddr[g])
    );
  end

  assign srcAddr = unitAddr[0];
  assign dstAddr = unitAddr[1];

endmodule

// File: rtl/dmaag_ctrl.sv
module dmaag_ctrl
  import dmaag_pkg::*;
#(
  parameter int HOP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [2:0]       cfgSel,
  input  logic [HOP_W-1:0] hopData,
  input  logic             enSet,
  input  logic             resumeMode,
  input  logic             contMode,
  input  logic             stepReq,
  input  logic             clrEnd,
  output pathCtl_t         ctl,
  output logic             stepAck,
  output logic             chanEn,
  output logic [HOP_W-1:0] hopLeft,
  output logic             endFlag
);

  logic [HOP_W-1:0] hopInit;
  logic             startReq;
  logic             lastHop;
  logic             hopZero;
  logic             endSet;

  always_comb begin
    startReq      = enSet & ~chanEn;
    hopZero       = (hopInit == '0);
    stepAck       = chanEn & stepReq & (hopLeft != '0);
    lastHop       = (hopLeft == HOP_W'(1));
    endSet        = (stepAck & lastHop) | (startReq & hopZero);
    ctl.loadStart = startReq & ~resumeMode;
    ctl.advance   = stepAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hopInit <= '0;
      chanEn  <= 1'b0;
      hopLeft <= '0;
      endFlag <= 1'b0;
    end else begin
      if (cfgWr && (cfgSel == 3'(SEL_HOPS))) hopInit <= hopData;
      endFlag <= endSet | (endFlag & ~clrEnd);
      if (startReq) begin
        if (!hopZero) begin
          chanEn  <= 1'b1;
          hopLeft <= hopInit;
        end
      end else if (stepAck) begin
        if (lastHop) begin
          if (contMode && !hopZero) begin
            hopLeft <= hopInit;
          end else begin
            chanEn  <= 1'b0;
            hopLeft <= '0;
          end
        end else begin
          hopLeft <= hopLeft - HOP_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dmaag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 16,
  parameter int HOP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              enSet,
  input  logic              resumeMode,
  input  logic              contMode,
  input  logic              stepReq,
  input  logic              clrEnd,
  output logic              stepAck,
  output logic              chanEn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [HOP_W-1:0]  hopLeft,
  output logic              endFlag
);

  pathCtl_t ctl;

  dmaag_ctrl #(.HOP_W(HOP_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgSel     (cfgSel),
    .hopData    (cfgData[HOP_W-1:0]),
    .enSet      (enSet),
    .resumeMode (resumeMode),
    .contMode   (contMode),
    .stepReq    (stepReq),
    .clrEnd     (clrEnd),
    .ctl        (ctl),
    .stepAck    (stepAck),
    .chanEn     (chanEn),
    .hopLeft    (hopLeft),
    .endFlag    (endFlag)
  );

  dmaag_path #(.ADDR_W(ADDR_W), .INC_W(INC_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .ctl     (ctl),
    .srcAddr (srcAddr),
    .dstAddr (dstAddr)
  );

endmodule

// File: rtl/dmaag_checker.sv
module dmaag_checker #(
  parameter int ADDR_W = 32,
  parameter int HOP_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic [2:0]        cfgSel,
  input logic [ADDR_W-1:0] cfgData,
  input logic              enSet,
  input logic              resumeMode,
  input logic              contMode,
  input logic              stepReq,
  input logic              clrEnd,
  input logic              stepAck,
  input logic              chanEn,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input logic [HOP_W-1:0]  hopLeft,
  input logic              endFlag
);

  // shadow of the masks as seen at the configuration port
  logic [ADDR_W-1:0] srcHoldSh, dstHoldSh;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcHoldSh <= '0;
      dstHoldSh <= '0;
    end else if (cfgWr) begin
      if (cfgSel == 3'd4) srcHoldSh <= cfgData;
      if (cfgSel == 3'd5) dstHoldSh <= cfgData;
    end
  end

  AST_ACK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    stepAck |-> (chanEn && stepReq)); // R3

  AST_SRC_FROZEN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    stepAck |=> (((srcAddr ^ $past(srcAddr)) & $past(srcHoldSh)) == '0)); // R4

  AST_DST_FROZEN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    stepAck |=> (((dstAddr ^ $past(dstAddr)) & $past(dstHoldSh)) == '0)); // R4

  AST_HOP_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stepAck && hopLeft > HOP_W'(1)) |=> (hopLeft == $past(hopLeft) - HOP_W'(1))); // R5

  AST_LAST_HOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (stepAck && hopLeft == HOP_W'(1)) |=> endFlag); // R5

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (stepAck && hopLeft == HOP_W'(1) && !contMode) |=> !chanEn); // R6

  AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && !enSet) |=> ($stable(srcAddr) && $stable(dstAddr))); // R6

  AST_RESUME_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (enSet && !chanEn && resumeMode) |=> ($stable(srcAddr) && $stable(dstAddr))); // R8

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrEnd && !stepAck && !(enSet && !chanEn)) |=> !endFlag); // R9

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !clrEnd) |=> endFlag); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (enSet && chanEn && !stepReq) |=> ($stable(hopLeft) && $stable(srcAddr) && chanEn)); // R10

endmodule

bind dma_addr_gen dmaag_checker #(.ADDR_W(ADDR_W), .HOP_W(HOP_W)) chk_i (.*);

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;

  localparam int AW = 12;
  localparam int IW = 8;
  localparam int HW = 4;

  typedef struct packed {
    logic [AW-1:0] sS;
    logic [IW-1:0] iS;
    logic [AW-1:0] mS;
    logic [AW-1:0] sD;
    logic [IW-1:0] iD;
    logic [AW-1:0] mD;
    logic [HW-1:0] hops;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t TABLE [NV] = '{
    '{12'h100, 8'h01, 12'h000, 12'h200, 8'h04, 12'h000, 4'd5},  // plain strides
    '{12'h3FE, 8'h01, 12'hFF8, 12'h0F0, 8'hFF, 12'hF00, 4'd6},  // circular window, negative
    '{12'hFFE, 8'h02, 12'h000, 12'h000, 8'h80, 12'h00F, 4'd3},  // wrap past top, -128
    '{12'h555, 8'h10, 12'h00F, 12'hABC, 8'hF0, 12'hC00, 4'd4}   // low bits frozen
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic enSet = 1'b0, resumeMode = 1'b0, contMode = 1'b0, stepReq = 1'b0, clrEnd = 1'b0;
  logic stepAck, chanEn, endFlag;
  logic [AW-1:0] srcAddr, dstAddr;
  logic [HW-1:0] hopLeft;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] es, ed, incS, incD, mskS, mskD;

  always #2 clk = ~clk;  // 250 MHz

  dma_addr_gen #(.ADDR_W(AW), .INC_W(IW), .HOP_W(HW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgData(cfgData),
    .enSet(enSet), .resumeMode(resumeMode), .contMode(contMode), .stepReq(stepReq),
    .clrEnd(clrEnd), .stepAck(stepAck), .chanEn(chanEn), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .hopLeft(hopLeft), .endFlag(endFlag)
  );

  function automatic logic [AW-1:0] model(input logic [AW-1:0] c, input logic [AW-1:0] i,
                                          input logic [AW-1:0] m);
    logic [AW-1:0] s;
    s = c + i;
    return (s & ~m) | (c & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic start(input logic res, input logic cont);
    @(negedge clk);
    enSet = 1'b1; resumeMode = res; contMode = cont;
    @(negedge clk);
    enSet = 1'b0;
  endtask

  task automatic step(input logic clr, input logic expAck);
    @(negedge clk);
    stepReq = 1'b1; clrEnd = clr;
    #1 chk("R3 ack", stepAck, expAck);
    @(negedge clk);
    stepReq = 1'b0; clrEnd = 1'b0;
    if (expAck) begin
      es = model(es, incS, mskS);
      ed = model(ed, incD, mskD);
    end
  endtask

  task automatic clearEnd();
    @(negedge clk);
    clrEnd = 1'b1;
    @(negedge clk);
    clrEnd = 1'b0;
    chk("R9 clear", endFlag, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 chanEn", chanEn, 1'b0);
    chk("R1 endFlag", endFlag, 1'b0);
    chk("R1 hopLeft", hopLeft, '0);
    chk("R1 srcAddr", srcAddr, '0);
    chk("R1 dstAddr", dstAddr, '0);

    // table-driven one-shot transfers
    for (int v = 0; v < NV; v++) begin
      cfg(3'd0, TABLE[v].sS);
      cfg(3'd1, TABLE[v].sD);
      cfg(3'd2, AW'(TABLE[v].iS));
      cfg(3'd3, AW'(TABLE[v].iD));
      cfg(3'd4, TABLE[v].mS);
      cfg(3'd5, TABLE[v].mD);
      cfg(3'd6, AW'(TABLE[v].hops));
      incS = AW'($signed(TABLE[v].iS));
      incD = AW'($signed(TABLE[v].iD));
      mskS = TABLE[v].mS;
      mskD = TABLE[v].mD;
      start(1'b0, 1'b0);
      es = TABLE[v].sS;
      ed = TABLE[v].sD;
      chk("R2 chanEn", chanEn, 1'b1);
      chk("R2 src start", srcAddr, es);
      chk("R2 dst start", dstAddr, ed);
      chk("R2 hops", hopLeft, TABLE[v].hops);
      for (int k = 0; k < int'(TABLE[v].hops); k++) begin
        step(1'b0, 1'b1);
        chk("R3 src", srcAddr, es);
        chk("R3 dst", dstAddr, ed);
        chk("R4 src frozen", srcAddr & mskS, TABLE[v].sS & mskS);
        chk("R4 dst frozen", dstAddr & mskD, TABLE[v].sD & mskD);
        chk("R5 count", hopLeft, HW'(int'(TABLE[v].hops) - k - 1));
      end
      chk("R5 end", endFlag, 1'b1);
      chk("R6 disarm", chanEn, 1'b0);
      clearEnd();
    end

    // R6 disarmed step request is ignored
    step(1'b0, 1'b0);
    chk("R6 src hold", srcAddr, es);
    chk("R6 dst hold", dstAddr, ed);

    // R8 resume keeps current addresses
    cfg(3'd0, 12'h700);
    cfg(3'd6, 12'd2);
    start(1'b1, 1'b0);
    chk("R8 resume src", srcAddr, es);
    chk("R8 resume dst", dstAddr, ed);
    chk("R8 armed", chanEn, 1'b1);
    step(1'b0, 1'b1);
    chk("R8 step src", srcAddr, es);
    step(1'b0, 1'b1);
    chk("R8 done", chanEn, 1'b0);
    clearEnd();

    // R7 continuous mode, with R9 clear racing the end event
    start(1'b0, 1'b1);
    es = 12'h700;
    ed = TABLE[3].sD;
    chk("R7 start src", srcAddr, es);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R9 set wins", endFlag, 1'b1);
    chk("R7 armed", chanEn, 1'b1);
    chk("R7 reload", hopLeft, HW'(2));
    step(1'b0, 1'b1);
    chk("R7 continue src", srcAddr, es);
    chk("R7 continue dst", dstAddr, ed);
    chk("R7 count", hopLeft, HW'(1));

    // R10 start while armed is ignored
    cfg(3'd0, 12'h123);
    start(1'b0, 1'b1);
    chk("R10 src", srcAddr, es);
    chk("R10 hops", hopLeft, HW'(1));
    chk("R10 armed", chanEn, 1'b1);

    // finish in one-shot mode
    @(negedge clk);
    contMode = 1'b0;
    step(1'b0, 1'b1);
    chk("R6 disarm", chanEn, 1'b0);
    clearEnd();

    // R11 zero hop count
    cfg(3'd6, 12'd0);
    start(1'b0, 1'b0);
    chk("R11 not armed", chanEn, 1'b0);
    chk("R11 end", endFlag, 1'b1);
    clearEnd();

    // R8 resume straight after reset uses reset start values
    doReset();
    cfg(3'd6, 12'd1);
    start(1'b1, 1'b0);
    chk("R8 reset src", srcAddr, '0);
    chk("R8 reset dst", dstAddr, '0);
    chk("R8 reset armed", chanEn, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule